// File: doc/BRIEF.md
# Serial Wire Debug Packet Engine

This block is the host end of a two-wire debug link. It produces the debug clock from the system clock with a fixed divider. It serialises one transaction request at a time onto the data line and deserialises what the target returns. A transfer command gives a port select (access port or debug port), a direction, the two register address bits [3:2] and a write word. The engine sends the 8-bit request header, releases the line for a turnaround slot and samples the 3-bit acknowledge. It then either runs the 33-bit data phase or ends the transfer early. The result comes back as the acknowledge code, the read word, a parity-error flag and a protocol-error flag.

Besides transfers, the engine can emit two fixed line sequences on request: the line reset (a long run of ones, optionally followed by low idle slots) and the 16-bit mode-switch pattern that moves a target from the boundary-scan protocol to the two-wire protocol. Retries after a WAIT, register meaning and multi-target selection are handled by the agent that issues the commands.

The bidirectional data pin is split at the block edge into an output value, an output enable and an input. The pad ring joins them.

Top module: `swd_engine`

## Requirements
- R1: The header goes out least significant bit first, one bit per slot. The bit order is: start (1), port select (1 = access port), direction (1 = read), address bit 2, address bit 3, parity, stop (0), park (1). The parity bit makes the number of ones over port select, direction and the two address bits even. The host drives every header slot.
- R2: The host releases the line (`swdio_oe` = 0) in the slot after the header and during the three acknowledge slots. On a successful read it stays released through the 33 data slots and one more turnaround slot. On a successful write it releases one turnaround slot and then drives all 33 data slots.
- R3: The acknowledge is sampled least significant bit first. `rsp_ack` bit 0 is the first bit sampled. 3'b001 (OK) continues with the data phase. 3'b010 (WAIT) and 3'b100 (FAULT) skip the data phase: the transfer ends after one turnaround slot, 13 slots in all. Any other code also skips the data phase, takes the same 13 slots and raises `rsp_proto_err`.
- R4: A successful read samples 32 data bits least significant bit first, then a parity bit. `rsp_rdata` returns the word. `rsp_par_err` is 1 exactly when the received parity bit differs from the XOR of the 32 data bits. It is 0 for every transfer that is not a successful read.
- R5: A successful write sends `cmd_wdata` least significant bit first, then one bit equal to the XOR of the 32 data bits.
- R6: `cmd_kind` = 1 selects the line reset: 56 slots with the line driven high, then 8 slots driven low when `cmd_idle_tail` is 1.
- R7: `cmd_kind` = 2 or 3 selects the mode switch: 16 driven slots carrying 16'hE79E, least significant bit first.
- R8: `busy` rises in the cycle after a command is accepted. It stays high until the cycle in which `done` pulses for one cycle, and falls in that cycle. A `cmd_valid` seen while `busy` is high is ignored: the running command's bits and its length do not change.
- R9: Each slot lasts 2*DIV_HALF system clocks. `swclk` is low for the first half of the slot and high for the second half, and the host samples the line at the rising edge. A successful transfer therefore takes 46*2*DIV_HALF cycles from accept to `done`.
- R10: After reset, and between commands, `swclk` is low, the host drives the line low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; taken only while idle |
| cmd_kind | input | 2 | 0 transfer, 1 line reset, 2 or 3 mode switch |
| cmd_ap | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_rnw | input | 1 | 1 read, 0 write |
| cmd_addr | input | 2 | Register address bits [3:2] |
| cmd_wdata | input | DATA_W | Write word |
| cmd_idle_tail | input | 1 | Append low idle slots after a line reset |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| rsp_ack | output | 3 | Acknowledge as sampled (0 for sequences) |
| rsp_rdata | output | DATA_W | Read word of a successful read, else 0 |
| rsp_par_err | output | 1 | Read parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was not OK, WAIT or FAULT |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Value driven onto the data line |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_in | input | 1 | Data line as seen at the pad |

## Verification
Every cycle, the assertions check four things. The sampling strobes fall only while the host has released the line. Each rising debug-clock edge follows a sampling strobe. `busy` falls only together with `done`, and the latched command holds while busy. A rejected acknowledge always ends after exactly 13 slots, and a parity error never comes with a non-OK acknowledge. Only the bench's scenarios can show the rest: the header bit order and parity for every port/direction/address combination, the data bit order and parity on the wire, the handling of all eight acknowledge codes, the exact reset and switch patterns, and that a command arriving mid-transfer leaves the wire untouched.

// File: rtl/swd_pkg.sv
package swd_pkg;

   typedef enum logic [1:0] {
      KIND_XFER       = 2'd0,
      KIND_LRESET     = 2'd1,
      KIND_SWITCH     = 2'd2,
      KIND_SWITCH_ALT = 2'd3
   } kind_e;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_HDR,
      PH_TRN_A,
      PH_ACK,
      PH_RD,
      PH_TRN_B,
      PH_WR,
      PH_LRST,
      PH_SWITCH
   } phase_e;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   // request header, bit 0 leaves first
   function automatic logic [7:0] make_header(input logic ap, input logic rnw,
                                              input logic [1:0] a);
      return {1'b1, 1'b0, ^{ap, rnw, a}, a[1], a[0], rnw, ap, 1'b1};
   endfunction

   function automatic logic ack_known(input logic [2:0] a);
      return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
   endfunction

endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic swclk,
   output logic sample_tick,
   output logic slot_end
);
   localparam int SLOT = 2 * DIV_HALF;
   localparam int CW   = $clog2(SLOT);
   localparam logic [CW-1:0] PRE_C  = CW'(DIV_HALF - 1);
   localparam logic [CW-1:0] HALF_C = CW'(DIV_HALF);
   localparam logic [CW-1:0] LAST_C = CW'(SLOT - 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("swd_clkgen: DIV_HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!run || cnt == LAST_C) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
   end

   assign swclk       = run && (cnt >= HALF_C);
   assign sample_tick = run && (cnt == PRE_C);
   assign slot_end    = run && (cnt == LAST_C);

   AST_RISE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(swclk) |-> $past(sample_tick))
      else $error("swclk rose without a preceding sample strobe"); // R9

endmodule

// File: rtl/swd_rx.sv
module swd_rx #(
   parameter int DATA_W       = 32,
   parameter bit CHECK_PARITY = 1'b1,
   parameter int IDX_W        = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              ack_en,
   input  logic              data_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic              din,
   input  logic              line_oe,
   output logic [2:0]        ack,
   output logic [DATA_W-1:0] data,
   output logic              par_err
);
   localparam int DW_IW = $clog2(DATA_W);

   generate
      if ((1 << IDX_W) <= DATA_W) begin : g_bad_idx
         $error("swd_rx: IDX_W too narrow for DATA_W plus parity");
      end
   endgenerate

   logic par_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack     <= '0;
         data    <= '0;
         par_bit <= 1'b0;
      end else if (clear) begin
         ack     <= '0;
         data    <= '0;
         par_bit <= 1'b0;
      end else begin
         if (ack_en) ack[idx[1:0]] <= din;
         if (data_en) begin
            if (idx < IDX_W'(DATA_W)) data[idx[DW_IW-1:0]] <= din;
            else                      par_bit <= din;
         end
      end
   end

   generate
      if (CHECK_PARITY) begin : g_par_chk
         assign par_err = (^data) != par_bit;
      end else begin : g_par_off
         assign par_err = 1'b0;
      end
   endgenerate

   AST_RX_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en || data_en) |-> !line_oe)
      else $error("sampling while host drives the line"); // R2

endmodule

// File: rtl/swd_engine.sv
module swd_engine
   import swd_pkg::*;
#(
   parameter int DIV_HALF                  = 2,
   parameter int DATA_W                    = 32,
   parameter int RST_ONES                  = 56,
   parameter int RST_IDLE                  = 8,
   parameter int SW_LEN                    = 16,
   parameter logic [SW_LEN-1:0] SW_PATTERN = 16'hE79E,
   parameter bit CHECK_PARITY              = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic              cmd_ap,
   input  logic              cmd_rnw,
   input  logic [1:0]        cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_idle_tail,
   output logic              busy,
   output logic              done,
   output logic [2:0]        rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_par_err,
   output logic              rsp_proto_err,
   output logic              swclk,
   output logic              swdio_out,
   output logic              swdio_oe,
   input  logic              swdio_in
);
   localparam int CNT_W = 7;
   localparam int DW_IW = $clog2(DATA_W);
   localparam int SW_IW = $clog2(SW_LEN);
   localparam logic [CNT_W-1:0] LAST_HDR   = 7'd7;
   localparam logic [CNT_W-1:0] LAST_ACK   = 7'd2;
   localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONES_C     = CNT_W'(RST_ONES);
   localparam logic [CNT_W-1:0] LAST_RST_S = CNT_W'(RST_ONES - 1);
   localparam logic [CNT_W-1:0] LAST_RST_L = CNT_W'(RST_ONES + RST_IDLE - 1);
   localparam logic [CNT_W-1:0] LAST_SW    = CNT_W'(SW_LEN - 1);
   localparam logic [CNT_W-1:0] REJECT_SLOTS = 7'd13;

   generate
      if (DATA_W < 2 || DATA_W > 126) begin : g_bad_dw
         $error("swd_engine: DATA_W out of range");
      end
      if (RST_ONES < 1 || RST_ONES + RST_IDLE > 127) begin : g_bad_rst
         $error("swd_engine: line reset length out of range");
      end
      if (SW_LEN < 2 || SW_LEN > 127) begin : g_bad_sw
         $error("swd_engine: switch pattern length out of range");
      end
   endgenerate

   phase_e             phase;
   logic [CNT_W-1:0]   bitcnt;
   logic [CNT_W-1:0]   slots;
   logic [CNT_W-1:0]   last_bit;
   logic [1:0]         l_kind;
   logic               l_ap, l_rnw, l_tail, go_write;
   logic [1:0]         l_addr;
   logic [DATA_W-1:0]  l_wdata;
   logic [7:0]         hdr;
   logic               sample_tick, slot_end, final_slot, is_xfer;
   logic [2:0]         rx_ack;
   logic [DATA_W-1:0]  rx_data;
   logic               rx_par_err;

   assign busy    = (phase != PH_IDLE);
   assign hdr     = make_header(l_ap, l_rnw, l_addr);
   assign is_xfer = (l_kind == KIND_XFER);

   swd_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (busy),
      .swclk       (swclk),
      .sample_tick (sample_tick),
      .slot_end    (slot_end)
   );

   swd_rx #(.DATA_W(DATA_W), .CHECK_PARITY(CHECK_PARITY), .IDX_W(CNT_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cmd_valid && !busy),
      .ack_en  (sample_tick && phase == PH_ACK),
      .data_en (sample_tick && phase == PH_RD),
      .idx     (bitcnt),
      .din     (swdio_in),
      .line_oe (swdio_oe),
      .ack     (rx_ack),
      .data    (rx_data),
      .par_err (rx_par_err)
   );

   // index of the last slot in the current phase
   always_comb begin
      case (phase)
         PH_HDR:    last_bit = LAST_HDR;
         PH_ACK:    last_bit = LAST_ACK;
         PH_RD,
         PH_WR:     last_bit = LAST_DATA;
         PH_LRST:   last_bit = l_tail ? LAST_RST_L : LAST_RST_S;
         PH_SWITCH: last_bit = LAST_SW;
         default:   last_bit = '0;
      endcase
   end

   assign final_slot = slot_end && (bitcnt == last_bit) &&
                       ((phase == PH_WR) || (phase == PH_LRST) ||
                        (phase == PH_SWITCH) || (phase == PH_TRN_B && !go_write));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bitcnt   <= '0;
         slots    <= '0;
         l_kind   <= '0;
         l_ap     <= 1'b0;
         l_rnw    <= 1'b0;
         l_addr   <= '0;
         l_wdata  <= '0;
         l_tail   <= 1'b0;
         go_write <= 1'b0;
      end else if (phase == PH_IDLE) begin
         if (cmd_valid) begin
            l_kind   <= cmd_kind;
            l_ap     <= cmd_ap;
            l_rnw    <= cmd_rnw;
            l_addr   <= cmd_addr;
            l_wdata  <= cmd_wdata;
            l_tail   <= cmd_idle_tail;
            bitcnt   <= '0;
            slots    <= '0;
            go_write <= 1'b0;
            if (cmd_kind == KIND_LRESET) phase <= PH_LRST;
            else if (cmd_kind[1])        phase <= PH_SWITCH;
            else                         phase <= PH_HDR;
         end
      end else if (slot_end) begin
         slots <= slots + 1'b1;
         if (bitcnt != last_bit) begin
            bitcnt <= bitcnt + 1'b1;
         end else begin
            bitcnt <= '0;
            case (phase)
               PH_HDR:   phase <= PH_TRN_A;
               PH_TRN_A: phase <= PH_ACK;
               PH_ACK: begin
                  if (rx_ack == ACK_OK && l_rnw) begin
                     phase <= PH_RD;
                  end else begin
                     phase    <= PH_TRN_B;
                     go_write <= (rx_ack == ACK_OK);
                  end
               end
               PH_RD:    phase <= PH_TRN_B;
               PH_TRN_B: phase <= go_write ? PH_WR : PH_IDLE;
               default:  phase <= PH_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done          <= 1'b0;
         rsp_ack       <= '0;
         rsp_rdata     <= '0;
         rsp_par_err   <= 1'b0;
         rsp_proto_err <= 1'b0;
      end else begin
         done <= final_slot;
         if (final_slot) begin
            rsp_ack       <= is_xfer ? rx_ack : 3'b000;
            rsp_rdata     <= (is_xfer && l_rnw && rx_ack == ACK_OK) ? rx_data : '0;
            rsp_par_err   <= is_xfer && l_rnw && (rx_ack == ACK_OK) && rx_par_err;
            rsp_proto_err <= is_xfer && !ack_known(rx_ack);
         end
      end
   end

   // line driver
   always_comb begin
      swdio_out = 1'b0;
      swdio_oe  = 1'b1;
      case (phase)
         PH_HDR:    swdio_out = hdr[bitcnt[2:0]];
         PH_TRN_A,
         PH_ACK,
         PH_RD,
         PH_TRN_B:  swdio_oe  = 1'b0;
         PH_WR:     swdio_out = (bitcnt < LAST_DATA) ? l_wdata[bitcnt[DW_IW-1:0]] : ^l_wdata;
         PH_LRST:   swdio_out = (bitcnt < ONES_C);
         PH_SWITCH: swdio_out = SW_PATTERN[bitcnt[SW_IW-1:0]];
         default:   swdio_out = 1'b0;
      endcase
   end

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("done while busy"); // R8
   AST_BUSY_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("busy dropped without done"); // R8
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({l_kind, l_ap, l_rnw, l_addr, l_wdata, l_tail}))
      else $error("latched command changed while busy"); // R8
   AST_SHORT_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_xfer && rsp_ack != ACK_OK) |-> (slots == REJECT_SLOTS))
      else $error("rejected transfer length wrong"); // R3
   AST_PERR_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_par_err) |-> (rsp_ack == ACK_OK))
      else $error("parity error on a transfer without data"); // R4
   AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !swclk)
      else $error("swclk toggling while idle"); // R9

endmodule

// File: tb/test_swd_engine.sv
module test_swd_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_kind = 2'd0;
   logic        cmd_ap = 1'b0, cmd_rnw = 1'b0, cmd_idle_tail = 1'b0;
   logic [1:0]  cmd_addr = 2'd0;
   logic [31:0] cmd_wdata = 32'd0;
   logic        busy, done, rsp_par_err, rsp_proto_err, swclk, swdio_out, swdio_oe, swdio_in;
   logic [2:0]  rsp_ack;
   logic [31:0] rsp_rdata;

   swd_engine i_swd_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_idle_tail(cmd_idle_tail), .busy(busy), .done(done), .rsp_ack(rsp_ack),
      .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err), .rsp_proto_err(rsp_proto_err),
      .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
   );

   int errors = 0;
   int checks = 0;

   // target model: slot index from falling swclk edges since command start
   logic [6:0]   nfall, nrise, base, rbase, ts;
   logic [127:0] tvec, hb, ho;

   always @(negedge swclk or negedge rst_n)
      if (!rst_n) nfall <= 7'd0;
      else        nfall <= nfall + 7'd1;

   always @(posedge swclk or negedge rst_n)
      if (!rst_n) begin
         nrise <= 7'd0;
         hb    <= '0;
         ho    <= '0;
      end else begin
         hb[ts] <= swdio_out;
         ho[ts] <= swdio_oe;
         nrise  <= nrise + 7'd1;
      end

   assign ts       = nfall - base;
   assign swdio_in = tvec[ts];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] kind, input logic ap, input logic rnw,
                        input logic [1:0] addr, input logic [31:0] wd, input logic tail,
                        input logic inject, output int cycles);
      bit ok;
      base  = nfall;
      rbase = nrise;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = kind; cmd_ap = ap; cmd_rnw = rnw;
      cmd_addr = addr; cmd_wdata = wd; cmd_idle_tail = tail;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8 busy after accept", 64'(busy), 64'(1));
      cycles = 0;
      ok = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         cycles++;
         if (inject && cycles == 10) begin
            cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_rnw = ~rnw; cmd_ap = ~ap;
            cmd_wdata = ~wd; cmd_addr = ~addr;
         end
         if (inject && cycles == 11) cmd_valid = 1'b0;
         if (done) begin
            ok = 1'b1;
            break;
         end
      end
      if (!ok) begin
         errors++;
         $display("FAIL R8 watchdog: actual no done expected done");
      end
   endtask

   task automatic after_done();
      @(negedge clk);
      chk("R8 done single pulse", 64'({done, busy}), 64'(0));
      chk("R10 idle line", 64'({swclk, swdio_oe, swdio_out}), 64'(3'b010));
   endtask

   task automatic xfer(input logic ap, input logic rnw, input logic [1:0] addr,
                       input logic [31:0] wd, input logic [2:0] ack,
                       input logic [31:0] rd, input logic flip, input logic inject);
      int cyc;
      logic [7:0] eh;
      logic known;
      logic [6:0] rises;
      tvec = '1;
      tvec[11:9] = ack;
      if (rnw) begin
         tvec[43:12] = rd;
         tvec[44]    = (^rd) ^ flip;
      end
      issue(2'd0, ap, rnw, addr, wd, 1'b0, inject, cyc);
      rises = nrise - rbase;
      eh = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
      known = (ack == 3'b001) || (ack == 3'b010) || (ack == 3'b100);
      chk("R1 header bits", 64'(hb[7:0]), 64'(eh));
      chk("R1 header driven", 64'(ho[7:0]), 64'(8'hff));
      chk("R2 released for ack", 64'(ho[11:8]), 64'(0));
      chk("R3 ack value", 64'(rsp_ack), 64'(ack));
      chk("R3 protocol error", 64'(rsp_proto_err), 64'(!known));
      if (ack == 3'b001 && rnw) begin
         chk("R4 read word", 64'(rsp_rdata), 64'(rd));
         chk("R4 parity flag", 64'(rsp_par_err), 64'(flip));
         chk("R2 released read data", 64'(ho[45:12]), 64'(0));
         chk("R9 transfer cycles", 64'(cyc), 64'(46 * 4));
         chk("R9 slot count", 64'(rises), 64'(46));
      end else if (ack == 3'b001) begin
         chk("R2 write turnaround", 64'(ho[12]), 64'(0));
         chk("R5 write word", 64'(hb[44:13]), 64'(wd));
         chk("R5 write parity", 64'(hb[45]), 64'(^wd));
         chk("R2 write driven", 64'(ho[45:13]), 64'(33'h1_ffff_ffff));
         chk("R9 slot count", 64'(rises), 64'(46));
         chk("R4 no parity flag on write", 64'(rsp_par_err), 64'(0));
      end else begin
         chk("R3 short transfer slots", 64'(rises), 64'(13));
         chk("R2 trailing turnaround", 64'(ho[12]), 64'(0));
         chk("R4 no parity flag", 64'(rsp_par_err), 64'(0));
      end
      after_done();
   endtask

   initial begin
      int cyc;
      logic [6:0] rises;
      tvec = '1;
      base = 7'd0;
      rbase = 7'd0;
      repeat (5) @(negedge clk);
      chk("R10 reset state", 64'({busy, done, swclk, swdio_oe, swdio_out}), 64'(5'b00010));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 idle after reset", 64'({busy, done, swclk, swdio_oe, swdio_out}), 64'(5'b00010));

      // header / data sweep over every port, direction and address
      for (int i = 0; i < 16; i++) begin
         logic [3:0] iv;
         logic [31:0] d;
         iv = 4'(i);
         d  = 32'h9E37_79B9 * 32'(i + 1);
         xfer(iv[0], iv[1], iv[3:2], d, 3'b001, d ^ 32'h5A5A_0F0F, (i % 3 == 0), 1'b0);
      end

      // every acknowledge code, both directions
      for (int a = 0; a < 8; a++) begin
         xfer(1'b1, 1'b1, 2'd1, 32'h1234_5678, 3'(a), 32'hCAFE_F00D, 1'b0, 1'b0);
         xfer(1'b0, 1'b0, 2'd2, 32'h0F1E_2D3C, 3'(a), 32'h0, 1'b0, 1'b0);
      end

      // data extremes
      xfer(1'b1, 1'b1, 2'd3, 32'h0, 3'b001, 32'h0000_0000, 1'b1, 1'b0);
      xfer(1'b1, 1'b1, 2'd3, 32'h0, 3'b001, 32'hFFFF_FFFF, 1'b0, 1'b0);
      xfer(1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF, 3'b001, 32'h0, 1'b0, 1'b0);
      xfer(1'b0, 1'b0, 2'd0, 32'h0000_0001, 3'b001, 32'h0, 1'b0, 1'b0);

      // command during busy must be ignored (R8)
      xfer(1'b1, 1'b0, 2'd1, 32'hA5C3_3C5A, 3'b001, 32'h0, 1'b0, 1'b1);
      repeat (20) @(negedge clk);
      chk("R8 ignored command started nothing", 64'({busy, swclk}), 64'(0));

      // line reset without and with idle tail
      tvec = '1;
      issue(2'd1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, cyc);
      rises = nrise - rbase;
      chk("R6 reset length", 64'(rises), 64'(56));
      chk("R6 reset ones", 64'(hb[55:0]), 64'(56'hff_ffff_ffff_ffff));
      chk("R6 reset driven", 64'(ho[55:0]), 64'(56'hff_ffff_ffff_ffff));
      after_done();
      issue(2'd1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 1'b0, cyc);
      rises = nrise - rbase;
      chk("R6 reset with tail length", 64'(rises), 64'(64));
      chk("R6 reset with tail bits", hb[63:0], 64'h00ff_ffff_ffff_ffff);
      chk("R6 tail driven", ho[63:0], 64'hffff_ffff_ffff_ffff);
      after_done();

      // mode switch, both codes
      for (int k = 2; k < 4; k++) begin
         issue(2'(k), 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, cyc);
         rises = nrise - rbase;
         chk("R7 switch length", 64'(rises), 64'(16));
         chk("R7 switch pattern", 64'(hb[15:0]), 64'(16'hE79E));
         chk("R7 switch driven", 64'(ho[15:0]), 64'(16'hffff));
         chk("R7 no ack on sequence", 64'(rsp_ack), 64'(0));
         after_done();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule